// File: doc/BRIEF.md
# Pipelined Dual-Port Word Memory

This block is a synchronous storage array shared by two independent ports, A and B. In any clock cycle, each port can read or write any word, and the two ports do not affect each other. A word is 36 bits wide, made of four 9-bit lanes. A write stores only the lanes whose lane enable is set. Every input a port presents is captured in a register at the clock edge. Read data passes through a second register before it reaches the output, so a read returns its data two clock edges after the request is driven.

Each port has two chip-enable pins with opposite polarity. A port takes part in a cycle only when its disable pin is low and its enable pin is high. After a cycle in which a port was deselected, or after reset, the port needs one selected cycle to come back. A read in that first selected cycle gives no output, although a write in that cycle still takes effect. Each output is a valid flag plus a data word. The data word is zero whenever the flag is low.

An asynchronous active-high reset clears all pipeline and output registers at once. The stored words are not affected. Both ports share one clock.

Top module: `dual_port_pipe_ram`

## Requirements
- R1: Both ports can read in the same cycle, including different addresses, and each returns its own word.
- R2: A read request sampled at clock edge N shows on the port's valid flag and data right after edge N+1, and not after edge N.
- R3: A write changes only the lanes whose enable bit is set. Enable bit i selects data bits 9i+8 down to 9i. The other lanes keep their earlier contents.
- R4: A port is deselected in a cycle when its disable pin is 1 or its enable pin is 0. A deselected write does not change the memory, and a deselected read leaves the valid flag at 0.
- R5: The valid flag is 1 only for a selected read. It is 0 for writes. While the flag is 0, the data output is all zeros.
- R6: A read in the first selected cycle after a deselected cycle gives valid 0. A write in that cycle is still stored.
- R7: If one port reads a word while the other port writes the same word in the same cycle, the read returns the contents from before the write.
- R8: While reset is high, both valid flags and both data outputs are 0 at once, without waiting for a clock edge. After reset, each port is in the deselected state, so its first selected read gives valid 0.
- R9: A read issued in the cycle after a write, on either port, returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Asynchronous active-high reset of the pipeline and outputs |
| a_dis | input | 1 | Port A disable; 1 deselects the port |
| a_en | input | 1 | Port A enable; 0 deselects the port |
| a_rd | input | 1 | Port A operation: 1 read, 0 write |
| a_be | input | 4 | Port A lane write enables |
| a_addr | input | AW | Port A word address |
| a_wdata | input | 36 | Port A write data |
| a_vld | output | 1 | Port A read data valid |
| a_rdata | output | 36 | Port A read data (zero when not valid) |
| b_dis | input | 1 | Port B disable; 1 deselects the port |
| b_en | input | 1 | Port B enable; 0 deselects the port |
| b_rd | input | 1 | Port B operation: 1 read, 0 write |
| b_be | input | 4 | Port B lane write enables |
| b_addr | input | AW | Port B word address |
| b_wdata | input | 36 | Port B write data |
| b_vld | output | 1 | Port B read data valid |
| b_rdata | output | 36 | Port B read data (zero when not valid) |

## Verification
The wake-up state of each port is held in a single register. If it is wrong, a valid flag turns on or off one read too early or too late, and this shows two edges after the first selected cycle that follows a deselected one. A lane-enable or address fault in the array does not show when the write happens. It shows only when that word is read back later, as wrong bits confined to one 9-bit lane. A wrong read-during-write ordering shows in the data of the colliding read, one edge after the collision is captured.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int NPORTS = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_en_t;

    // Registered per-port control captured at the clock edge.
    typedef struct packed {
        logic     sel;
        logic     rd;
        lane_en_t be;
    } port_ctl_t;

    // A port takes part only with its disable low and its enable high.
    function automatic logic port_sel(input logic dis, input logic en);
        return !dis && en;
    endfunction

    // Expand lane enables into a full-width bit mask.
    function automatic word_t lane_mask(input lane_en_t be);
        word_t m;
        for (int l = 0; l < LANES; l++) begin
            m[l*LANE_W +: LANE_W] = {LANE_W{be[l]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dis,
    input  logic          en,
    input  logic          rd,
    input  lane_en_t      be,
    input  logic [AW-1:0] addr,
    input  word_t         wdata,
    output port_ctl_t     ctl_q,
    output logic [AW-1:0] addr_q,
    output word_t         wdata_q,
    output logic          vld
);

    logic pin_sel;
    logic awake_q;
    logic vld_q;

    assign pin_sel = port_sel(dis, en);

    // Input capture stage plus wake tracking and output valid stage.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            awake_q <= 1'b0;
            vld_q   <= 1'b0;
        end else begin
            ctl_q   <= '{sel: pin_sel, rd: rd, be: be};
            addr_q  <= addr;
            wdata_q <= wdata;
            awake_q <= ctl_q.sel;
            vld_q   <= ctl_q.sel && ctl_q.rd && awake_q;
        end
    end

    assign vld = vld_q;

    // R5: valid only follows a read presented two edges earlier
    assert_valid_from_read_R5: assert property (@(posedge clk) disable iff (rst)
        vld |-> $past(rd, 2));

    // R4: a deselected request never yields valid output
    assert_deselect_blanks_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(pin_sel, 2) |-> !vld);

    // R6: valid needs the cycle before the read to have been selected too
    assert_wake_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        vld |-> $past(pin_sel, 3));

endmodule

// File: rtl/dpr_array.sv
module dpr_array
    import dpr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we    [NPORTS],
    input  logic          re    [NPORTS],
    input  lane_en_t      be    [NPORTS],
    input  logic [AW-1:0] addr  [NPORTS],
    input  word_t         wdata [NPORTS],
    output word_t         rdata [NPORTS]
);

    localparam int DEPTH = 1 << AW;

    word_t mem [DEPTH];
    word_t rdata_q [NPORTS];

    // Lane-granular writes; a same-word collision has no defined result.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORTS; p++) begin
            for (int l = 0; l < LANES; l++) begin
                if (we[p] && be[p][l]) begin
                    mem[addr[p]][l*LANE_W +: LANE_W] <= wdata[p][l*LANE_W +: LANE_W];
                end
            end
        end
    end

    // Read register: samples the array before this edge's writes land.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int p = 0; p < NPORTS; p++) rdata_q[p] <= '0;
        end else begin
            for (int p = 0; p < NPORTS; p++) begin
                if (re[p]) rdata_q[p] <= mem[addr[p]];
            end
        end
    end

    assign rdata = rdata_q;

    // R3: bits outside the enabled lanes survive a write
    for (genvar gp = 0; gp < NPORTS; gp++) begin : g_lane_chk
        localparam int OP = NPORTS - 1 - gp;
        assert_lanes_kept_R3: assert property (@(posedge clk) disable iff (rst)
            (we[gp] && !(we[OP] && addr[OP] == addr[gp]))
            |=> (((mem[$past(addr[gp])] ^ $past(mem[addr[gp]]))
                  & ~lane_mask($past(be[gp]))) == '0));
    end

endmodule

// File: rtl/dual_port_pipe_ram.sv
module dual_port_pipe_ram
    import dpr_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_dis,
    input  logic          a_en,
    input  logic          a_rd,
    input  logic [3:0]    a_be,
    input  logic [AW-1:0] a_addr,
    input  logic [35:0]   a_wdata,
    output logic          a_vld,
    output logic [35:0]   a_rdata,
    input  logic          b_dis,
    input  logic          b_en,
    input  logic          b_rd,
    input  logic [3:0]    b_be,
    input  logic [AW-1:0] b_addr,
    input  logic [35:0]   b_wdata,
    output logic          b_vld,
    output logic [35:0]   b_rdata
);

    logic          dis_v   [NPORTS];
    logic          en_v    [NPORTS];
    logic          rd_v    [NPORTS];
    lane_en_t      be_v    [NPORTS];
    logic [AW-1:0] addr_v  [NPORTS];
    word_t         wd_v    [NPORTS];

    port_ctl_t     ctl_q   [NPORTS];
    logic [AW-1:0] addr_q  [NPORTS];
    word_t         wdata_q [NPORTS];
    logic          vld_v   [NPORTS];
    logic          we_v    [NPORTS];
    logic          re_v    [NPORTS];
    lane_en_t      wbe_v   [NPORTS];
    word_t         rdat_v  [NPORTS];

    assign dis_v[0]  = a_dis;    assign dis_v[1]  = b_dis;
    assign en_v[0]   = a_en;     assign en_v[1]   = b_en;
    assign rd_v[0]   = a_rd;     assign rd_v[1]   = b_rd;
    assign be_v[0]   = a_be;     assign be_v[1]   = b_be;
    assign addr_v[0] = a_addr;   assign addr_v[1] = b_addr;
    assign wd_v[0]   = a_wdata;  assign wd_v[1]   = b_wdata;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        dpr_port_ctrl #(.AW(AW)) u_ctrl (
            .clk     (clk),
            .rst     (rst),
            .dis     (dis_v[p]),
            .en      (en_v[p]),
            .rd      (rd_v[p]),
            .be      (be_v[p]),
            .addr    (addr_v[p]),
            .wdata   (wd_v[p]),
            .ctl_q   (ctl_q[p]),
            .addr_q  (addr_q[p]),
            .wdata_q (wdata_q[p]),
            .vld     (vld_v[p])
        );
        assign we_v[p]  = ctl_q[p].sel && !ctl_q[p].rd;
        assign re_v[p]  = ctl_q[p].sel &&  ctl_q[p].rd;
        assign wbe_v[p] = ctl_q[p].be;
    end

    dpr_array #(.AW(AW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (we_v),
        .re    (re_v),
        .be    (wbe_v),
        .addr  (addr_q),
        .wdata (wdata_q),
        .rdata (rdat_v)
    );

    assign a_vld   = vld_v[0];
    assign b_vld   = vld_v[1];
    assign a_rdata = vld_v[0] ? rdat_v[0] : '0;
    assign b_rdata = vld_v[1] ? rdat_v[1] : '0;

endmodule

// File: tb/dual_port_pipe_ram_tb.sv
module dual_port_pipe_ram_tb;

    localparam int AW = 8;
    localparam int NV = 10;

    typedef struct packed {
        logic a_dis; logic a_en; logic a_rd; logic [3:0] a_be; logic [7:0] a_addr; logic [35:0] a_wd;
        logic b_dis; logic b_en; logic b_rd; logic [3:0] b_be; logic [7:0] b_addr; logic [35:0] b_wd;
        logic a_xv; logic b_xv;
    } vec_t;

    localparam logic [35:0] D0 = 36'hA_5A5A_5A5A;
    localparam logic [35:0] D1 = 36'h3_C3C3_0F0F;
    localparam logic [35:0] D2 = 36'hF_FFFF_FFFF;
    localparam logic [35:0] D3 = 36'h1_2345_6789;
    localparam logic [35:0] D4 = 36'h0_0000_0000;
    localparam logic [35:0] D5 = 36'hE_DCBA_9876;
    localparam logic [35:0] D6 = 36'h7_0F1E_2D3C;
    localparam logic [35:0] D7 = 36'h5_5555_AAAA;

    // Each row: port A request, port B request, expected valid for A and B.
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,4'hF,8'd10,D0,   1'b0,1'b1,1'b0,4'hF,8'd20,D1,   1'b0,1'b0},
        '{1'b0,1'b1,1'b1,4'hF,8'd20,36'd0,1'b0,1'b1,1'b1,4'hF,8'd10,36'd0,1'b1,1'b1},
        '{1'b0,1'b1,1'b0,4'h5,8'd10,D2,   1'b0,1'b1,1'b1,4'hF,8'd10,36'd0,1'b0,1'b1},
        '{1'b0,1'b1,1'b1,4'hF,8'd10,36'd0,1'b1,1'b1,1'b1,4'hF,8'd20,36'd0,1'b1,1'b0},
        '{1'b0,1'b1,1'b1,4'hF,8'd20,36'd0,1'b0,1'b1,1'b1,4'hF,8'd20,36'd0,1'b1,1'b0},
        '{1'b0,1'b0,1'b0,4'hF,8'd20,D3,   1'b0,1'b1,1'b1,4'hF,8'd20,36'd0,1'b0,1'b1},
        '{1'b0,1'b1,1'b1,4'hF,8'd20,36'd0,1'b0,1'b1,1'b1,4'hF,8'd20,36'd0,1'b0,1'b1},
        '{1'b0,1'b1,1'b1,4'hF,8'd20,36'd0,1'b0,1'b1,1'b0,4'hF,8'd30,D4,   1'b1,1'b0},
        '{1'b0,1'b1,1'b1,4'hF,8'd10,36'd0,1'b0,1'b1,1'b0,4'h8,8'd30,D5,   1'b1,1'b0},
        '{1'b0,1'b1,1'b1,4'hF,8'd30,36'd0,1'b0,1'b1,1'b1,4'hF,8'd10,36'd0,1'b1,1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          a_dis = 1'b1, a_en = 1'b1, a_rd = 1'b1;
    logic [3:0]    a_be = 4'h0;
    logic [AW-1:0] a_addr = '0;
    logic [35:0]   a_wdata = '0;
    logic          b_dis = 1'b1, b_en = 1'b1, b_rd = 1'b1;
    logic [3:0]    b_be = 4'h0;
    logic [AW-1:0] b_addr = '0;
    logic [35:0]   b_wdata = '0;
    logic          a_vld, b_vld;
    logic [35:0]   a_rdata, b_rdata;

    int checks = 0;
    int fails  = 0;

    logic [35:0] shadow [256];
    logic [35:0] exp_ad [NV];
    logic [35:0] exp_bd [NV];

    always #2 clk = ~clk;

    dual_port_pipe_ram #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst),
        .a_dis(a_dis), .a_en(a_en), .a_rd(a_rd), .a_be(a_be), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_vld(a_vld), .a_rdata(a_rdata),
        .b_dis(b_dis), .b_en(b_en), .b_rd(b_rd), .b_be(b_be), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_vld(b_vld), .b_rdata(b_rdata)
    );

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic [3:0] be);
        logic [35:0] r = old;
        for (int l = 0; l < 4; l++) if (be[l]) r[l*9 +: 9] = nw[l*9 +: 9];
        return r;
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_a(input logic dis, input logic en, input logic rd, input logic [3:0] be,
                           input logic [7:0] ad, input logic [35:0] wd);
        a_dis = dis; a_en = en; a_rd = rd; a_be = be; a_addr = ad; a_wdata = wd;
    endtask

    task automatic drive_b(input logic dis, input logic en, input logic rd, input logic [3:0] be,
                           input logic [7:0] ad, input logic [35:0] wd);
        b_dis = dis; b_en = en; b_rd = rd; b_be = be; b_addr = ad; b_wdata = wd;
    endtask

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R8: outputs held at zero while reset is high
        @(negedge clk);
        @(negedge clk);
        check("R8 reset a_vld", {35'd0, a_vld}, 36'd0);
        check("R8 reset b_rdata", b_rdata, 36'd0);
        rst = 1'b0;

        // Table walk: row i is driven, row i-1 is checked one cycle later.
        for (int i = 0; i <= NV; i++) begin
            if (i < NV) begin
                drive_a(VECS[i].a_dis, VECS[i].a_en, VECS[i].a_rd, VECS[i].a_be, VECS[i].a_addr, VECS[i].a_wd);
                drive_b(VECS[i].b_dis, VECS[i].b_en, VECS[i].b_rd, VECS[i].b_be, VECS[i].b_addr, VECS[i].b_wd);
                // R7: reads see contents before this cycle's writes
                exp_ad[i] = VECS[i].a_xv ? shadow[VECS[i].a_addr] : 36'd0;
                exp_bd[i] = VECS[i].b_xv ? shadow[VECS[i].b_addr] : 36'd0;
                if (!VECS[i].a_dis && VECS[i].a_en && !VECS[i].a_rd)
                    shadow[VECS[i].a_addr] = merge(shadow[VECS[i].a_addr], VECS[i].a_wd, VECS[i].a_be);
                if (!VECS[i].b_dis && VECS[i].b_en && !VECS[i].b_rd)
                    shadow[VECS[i].b_addr] = merge(shadow[VECS[i].b_addr], VECS[i].b_wd, VECS[i].b_be);
            end else begin
                drive_a(1'b1, 1'b1, 1'b1, 4'h0, 8'd0, 36'd0);
                drive_b(1'b1, 1'b1, 1'b1, 4'h0, 8'd0, 36'd0);
            end
            @(negedge clk);
            if (i >= 1) begin
                // R1 R3 R4 R5 R6 R7 R9 covered by the rows above
                check($sformatf("R1/R4/R5/R6 row %0d a_vld", i-1), {35'd0, a_vld}, {35'd0, VECS[i-1].a_xv});
                check($sformatf("R1/R4/R5/R6 row %0d b_vld", i-1), {35'd0, b_vld}, {35'd0, VECS[i-1].b_xv});
                check($sformatf("R3/R7/R9 row %0d a_rdata", i-1), a_rdata, exp_ad[i-1]);
                check($sformatf("R3/R7/R9 row %0d b_rdata", i-1), b_rdata, exp_bd[i-1]);
            end
        end

        // R3 spot check on the lane merge expected for word 30
        check("R3 word30 lanes", shadow[30], {D5[35:27], D4[26:0]});

        // R2: latency, starting from a deselected port A
        drive_a(1'b0, 1'b1, 1'b0, 4'hF, 8'd40, D6);
        @(negedge clk);
        drive_a(1'b0, 1'b1, 1'b1, 4'hF, 8'd40, 36'd0);
        @(negedge clk);
        check("R2 one edge after read a_vld", {35'd0, a_vld}, 36'd0);
        drive_a(1'b0, 1'b1, 1'b0, 4'hF, 8'd41, D7);
        @(negedge clk);
        check("R2 two edges after read a_vld", {35'd0, a_vld}, 36'd1);
        check("R9 same-port write then read", a_rdata, D6);

        // R8: asynchronous clear in the middle of a read
        drive_a(1'b0, 1'b1, 1'b1, 4'hF, 8'd40, 36'd0);
        @(negedge clk);
        drive_a(1'b0, 1'b1, 1'b1, 4'hF, 8'd40, 36'd0);
        @(posedge clk);
        #1;
        check("R8 pre-reset a_vld", {35'd0, a_vld}, 36'd1);
        rst = 1'b1;
        #0.5;
        check("R8 async clear a_vld", {35'd0, a_vld}, 36'd0);
        check("R8 async clear a_rdata", a_rdata, 36'd0);
        @(negedge clk);
        rst = 1'b0;
        drive_a(1'b0, 1'b1, 1'b1, 4'hF, 8'd40, 36'd0);
        @(negedge clk);
        drive_a(1'b0, 1'b1, 1'b1, 4'hF, 8'd40, 36'd0);
        @(negedge clk);
        check("R8 first read after reset a_vld", {35'd0, a_vld}, 36'd0);
        drive_a(1'b1, 1'b1, 1'b1, 4'h0, 8'd0, 36'd0);
        @(negedge clk);
        check("R8 second read after reset a_vld", {35'd0, a_vld}, 36'd1);
        check("R8 memory kept across reset", a_rdata, D6);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule